// File: doc/BRIEF.md
# ALU Operation Select Decoder

This block sits between a processor's main instruction decoder and its ALU. The main decoder gives a 2-bit class code. For register-register instructions the block also looks at the 6-bit function field. From these two inputs it forms the operation select that drives the ALU. The opcode never reaches this block. Register-register instructions all share one opcode, so the main decoder cannot tell them apart, and the unsigned compare has to be recognised here.

The result has two parts: a 4-bit operation code and a flag that makes set-less-than compare without sign. It is placed on an 8-bit bus whose top three bits are always zero. The result is registered, so the select for a given pair of inputs appears one clock after those inputs are sampled. Signed and unsigned add give the same control value. The block does not detect or report overflow.

Top module: `aluctl_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, `ctl_o` becomes 8'h00 at that edge.
- R2: `ctl_o` is registered. It shows the decode of the `mode_i` and `fn_i` values sampled at the previous rising edge and holds steady between edges.
- R3: For `mode_i` = 2'b00, the operation is add (4'b0010) and the unsigned flag is 0, whatever `fn_i` holds.
- R4: For `mode_i` = 2'b01, the operation is subtract (4'b0110) and the unsigned flag is 0, whatever `fn_i` holds.
- R5: For `mode_i` = 2'b10, `fn_i` 6'b100000 and 6'b100001 both give add (4'b0010), and `fn_i` 6'b100010 and 6'b100011 both give subtract (4'b0110). The unsigned flag is 0 in all four cases.
- R6: For `mode_i` = 2'b10, `fn_i` 6'b100100 gives AND (4'b0000), 6'b100101 gives OR (4'b0001) and 6'b100111 gives NOR (4'b1100). The unsigned flag is 0 in all three cases.
- R7: For `mode_i` = 2'b10, `fn_i` 6'b101010 gives set-less-than (4'b0111) with the unsigned flag 0, and 6'b101011 gives set-less-than with the unsigned flag 1.
- R8: For `mode_i` = 2'b10, any function code not listed in R5 to R7 gives add with the unsigned flag 0.
- R9: `mode_i` = 2'b11 has no meaning of its own. It gives add with the unsigned flag 0, whatever `fn_i` holds.
- R10: The bus layout is fixed: `ctl_o[3:0]` holds the operation code, `ctl_o[4]` holds the unsigned flag, and `ctl_o[7:5]` is always 0.
- R11: The unsigned flag is 1 only when the operation code is set-less-than.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Instruction class from the main decoder |
| fn_i | input | 6 | Function field of the instruction |
| ctl_o | output | 8 | Registered select: operation [3:0], unsigned flag [4], zero [7:5] |

## Verification
Every decode result is due exactly one rising edge after its inputs are applied, because a single output register is the only state between the inputs and the output. The bench drives inputs on the falling edge and checks the output a short time after the next rising edge, so each check sees only the result of the inputs it drove. A back-to-back scenario changes the inputs every cycle. It also samples the output just before an edge to show that a new input has not yet reached the output.

// File: rtl/aluctl_pkg.sv
package aluctl_pkg;
  localparam int OP_W   = 4;
  localparam int MODE_W = 2;

  localparam logic [OP_W-1:0] OP_AND = 4'b0000;
  localparam logic [OP_W-1:0] OP_OR  = 4'b0001;
  localparam logic [OP_W-1:0] OP_ADD = 4'b0010;
  localparam logic [OP_W-1:0] OP_SUB = 4'b0110;
  localparam logic [OP_W-1:0] OP_SLT = 4'b0111;
  localparam logic [OP_W-1:0] OP_NOR = 4'b1100;

  typedef enum logic [MODE_W-1:0] {
    MODE_ADD   = 2'b00,
    MODE_SUB   = 2'b01,
    MODE_FIELD = 2'b10,
    MODE_SPARE = 2'b11
  } mode_e;

  typedef struct packed {
    logic            uns;
    logic [OP_W-1:0] op;
  } sel_t;
endpackage

// File: rtl/aluctl_fn_dec.sv
module aluctl_fn_dec
  import aluctl_pkg::*;
#(
  parameter int FN_W = 6
) (
  input  logic [FN_W-1:0] fn_i,
  output sel_t            sel_o,
  output logic            hit_o
);
  always_comb begin
    sel_o = '{uns: 1'b0, op: OP_ADD};
    hit_o = 1'b1;
    case (fn_i)
      6'b100000, 6'b100001: sel_o.op = OP_ADD;
      6'b100010, 6'b100011: sel_o.op = OP_SUB;
      6'b100100:            sel_o.op = OP_AND;
      6'b100101:            sel_o.op = OP_OR;
      6'b100111:            sel_o.op = OP_NOR;
      6'b101010:            sel_o.op = OP_SLT;
      6'b101011:            sel_o = '{uns: 1'b1, op: OP_SLT};
      default:              hit_o = 1'b0;
    endcase
  end

  always_comb begin
    if (!hit_o)
      AST_MISS_IS_ADD: assert (sel_o.op == OP_ADD && !sel_o.uns); // R8
  end
endmodule

// File: rtl/aluctl_mode_sel.sv
module aluctl_mode_sel
  import aluctl_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  sel_t              fld_i,
  input  logic              hit_i,
  output sel_t              sel_o
);
  always_comb begin
    sel_o = '{uns: 1'b0, op: OP_ADD};
    case (mode_e'(mode_i))
      MODE_ADD:   sel_o.op = OP_ADD;
      MODE_SUB:   sel_o.op = OP_SUB;
      MODE_FIELD: if (hit_i) sel_o = fld_i;
      default:    sel_o.op = OP_ADD;
    endcase
  end

  always_comb begin
    AST_UNS_ONLY_SLT: assert (!sel_o.uns || sel_o.op == OP_SLT); // R11
  end
endmodule

// File: rtl/aluctl_pack.sv
module aluctl_pack
  import aluctl_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  sel_t             sel_i,
  output logic [BUS_W-1:0] bus_o
);
  localparam int PAY_W = OP_W + 1;
  localparam int PAD_W = BUS_W - PAY_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign bus_o = {{PAD_W{1'b0}}, sel_i.uns, sel_i.op};
    end else begin : g_nopad
      assign bus_o = {sel_i.uns, sel_i.op};
    end
  endgenerate
endmodule

// File: rtl/aluctl_decoder.sv
module aluctl_decoder
  import aluctl_pkg::*;
#(
  parameter int FN_W  = 6,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic [FN_W-1:0]  fn_i,
  output logic [BUS_W-1:0] ctl_o
);
  sel_t             fld_sel;
  logic             fld_hit;
  sel_t             nxt_sel;
  logic [BUS_W-1:0] nxt_bus;

  aluctl_fn_dec #(.FN_W(FN_W)) u_fn (
    .fn_i  (fn_i),
    .sel_o (fld_sel),
    .hit_o (fld_hit)
  );

  aluctl_mode_sel u_mode (
    .mode_i (mode_i),
    .fld_i  (fld_sel),
    .hit_i  (fld_hit),
    .sel_o  (nxt_sel)
  );

  aluctl_pack #(.BUS_W(BUS_W)) u_pack (
    .sel_i (nxt_sel),
    .bus_o (nxt_bus)
  );

  always_ff @(posedge clk) begin
    if (rst) ctl_o <= '0;
    else     ctl_o <= nxt_bus;
  end

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctl_o[BUS_W-1:OP_W+1] == '0); // R10
  AST_MODE0_ADD: assert property (@(posedge clk) disable iff (rst)
    mode_i == 2'b00 |=> (ctl_o[3:0] == OP_ADD && !ctl_o[4])); // R3
  AST_MODE1_SUB: assert property (@(posedge clk) disable iff (rst)
    mode_i == 2'b01 |=> (ctl_o[3:0] == OP_SUB && !ctl_o[4])); // R4
  AST_MODE3_ADD: assert property (@(posedge clk) disable iff (rst)
    mode_i == 2'b11 |=> (ctl_o[3:0] == OP_ADD && !ctl_o[4])); // R9
  AST_UNS_SLT: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b10 && fn_i == 6'b101011) |=> (ctl_o[4:0] == 5'b10111)); // R7
  AST_SIGNED_SLT: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b10 && fn_i == 6'b101010) |=> (ctl_o[4:0] == 5'b00111)); // R7
endmodule

// File: tb/aluctl_decoder_test.sv
`timescale 1ns/1ps
module aluctl_decoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_i = 2'b00;
  logic [5:0] fn_i = 6'b0;
  logic [7:0] ctl_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  aluctl_decoder uut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .fn_i(fn_i), .ctl_o(ctl_o)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // drive on falling edge, sample 2 ns after the next rising edge
  task automatic apply(input string req, input logic [1:0] m, input logic [5:0] f,
                       input logic [7:0] exp);
    @(negedge clk);
    mode_i = m;
    fn_i = f;
    @(posedge clk);
    #2;
    check(req, ctl_o, exp);
  endtask

  task automatic t_reset();
    apply("R1 pre", 2'b10, 6'b101011, 8'h17);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    check("R1", ctl_o, 8'h00);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_mode_fixed();
    apply("R3 fn0", 2'b00, 6'b000000, 8'h02);
    apply("R3 fnslt", 2'b00, 6'b101011, 8'h02);
    apply("R3 fnand", 2'b00, 6'b100100, 8'h02);
    apply("R4 fn0", 2'b01, 6'b000000, 8'h06);
    apply("R4 fnsltu", 2'b01, 6'b101011, 8'h06);
    apply("R4 fnor", 2'b01, 6'b100101, 8'h06);
  endtask

  task automatic t_arith();
    apply("R5 add", 2'b10, 6'b100000, 8'h02);
    apply("R5 addu", 2'b10, 6'b100001, 8'h02);
    apply("R5 sub", 2'b10, 6'b100010, 8'h06);
    apply("R5 subu", 2'b10, 6'b100011, 8'h06);
  endtask

  task automatic t_logic();
    apply("R6 and", 2'b10, 6'b100100, 8'h00);
    apply("R6 or", 2'b10, 6'b100101, 8'h01);
    apply("R6 nor", 2'b10, 6'b100111, 8'h0C);
  endtask

  task automatic t_compare();
    apply("R7 slt", 2'b10, 6'b101010, 8'h07);
    apply("R7 sltu", 2'b10, 6'b101011, 8'h17);
    apply("R11 after sltu", 2'b10, 6'b100010, 8'h06);
  endtask

  task automatic t_unknown();
    apply("R8 xor", 2'b10, 6'b100110, 8'h02);
    apply("R8 zero", 2'b10, 6'b000000, 8'h02);
    apply("R8 ones", 2'b10, 6'b111111, 8'h02);
    apply("R8 near", 2'b10, 6'b101001, 8'h02);
  endtask

  task automatic t_spare();
    apply("R9 sltu", 2'b11, 6'b101011, 8'h02);
    apply("R9 nor", 2'b11, 6'b100111, 8'h02);
    apply("R9 sub", 2'b11, 6'b100010, 8'h06 ^ 8'h04);
  endtask

  task automatic t_timing();
    apply("R2 base", 2'b10, 6'b100111, 8'h0C);
    @(negedge clk);
    mode_i = 2'b10; fn_i = 6'b101011;
    #3;
    check("R2 hold", ctl_o, 8'h0C);
    @(posedge clk); #2;
    check("R2 step", ctl_o, 8'h17);
    for (int i = 0; i < 8; i++) begin
      logic [5:0] f;
      logic [7:0] e;
      f = (i % 2 == 0) ? 6'b100101 : 6'b101010;
      e = (i % 2 == 0) ? 8'h01 : 8'h07;
      apply("R2 toggle", 2'b10, f, e);
      check("R10 pad", {5'b0, ctl_o[7:5]}, 8'h00);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 init", ctl_o, 8'h00);
    @(negedge clk); rst = 1'b0;
    t_mode_fixed();
    t_arith();
    t_logic();
    t_compare();
    t_unknown();
    t_spare();
    t_timing();
    t_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule